// File: doc/BRIEF.md
# Latency-hinted fetch buffer controller

This block sits in an instruction fetch path whose cache sets do not all answer in the same number of cycles. It keeps one whole cache block in a local buffer. A fetch request whose block is already buffered is answered on the next cycle and causes no cache access. Otherwise the controller issues a single read of the whole block and waits a number of cycles taken from a latency hint. When that wait expires, it captures the block into the buffer and returns the requested word.

The hint is not supplied by the cache and is not a worst-case constant. Software places it in spare bits of certain instructions: the last word of every block, and any word that has its branch flag set. The controller picks the hint up as such an instruction leaves the block. After reset and after every redirect (a mispredict or an exception entry), the next cache read waits the longest latency, whatever hint is held.

Parameter `NUM_LAT` selects the latency set. With the value 3, a two-bit hint selects 3, 4 or 5 cycles. With the value 2, a one-bit hint selects 1 cycle (code 0) or 2 cycles (code 1).

Requests and instructions use valid/ready handshakes. A request is taken only when the controller holds no undelivered instruction, or when that instruction is taken in the same cycle, and never while a redirect is asserted. Back-pressure on the instruction output holds the word and its valid flag steady.

Top module: `hintfetch_ctrl`

## Requirements
- R1: A request whose block (address bits above the 4-byte word index and 2-bit byte offset) matches the valid buffer is delivered with out_valid in the cycle after acceptance, and no cache read is issued.
- R2: On a buffer miss, cache_rd_en pulses for exactly one cycle, in the cycle after acceptance, with cache_rd_addr equal to the request address with its low 4 bits cleared. The whole block is then captured and the word at index req_pc[3:2] is delivered. Request addresses are word aligned.
- R3: Data is captured at the end of the L-th cycle after the read cycle, so out_valid rises 2+L cycles after the acceptance cycle, where L is the selected wait. req_ready stays low during a miss.
- R4: The hint is bits [25:24] of a delivered instruction. It is latched only when that word is the last of its block (index 3) or has bit 26 set. Every other delivered word leaves the held hint unchanged.
- R5: With three latencies, hint code 0 waits 3 cycles, code 1 waits 4, and codes 2 and 3 wait 5.
- R6: A redirect pulse abandons any read in flight and any undelivered instruction, so out_valid stays low. The buffer keeps its previous block, which still hits.
- R7: The first cache read after reset or after a redirect waits the longest latency (5), whatever hint is held. A buffer hit does not consume this rule.
- R8: While out_valid is high and out_ready is low, out_valid and out_instr stay unchanged. After reset, req_ready is high, out_valid is low and no read is issued.
- R9: stall_cnt starts at 0 and rises by one for every cycle spent issuing or waiting on a cache read, including a cycle in which a redirect arrives.
- R10: A cache read whose true latency equals the hinted wait delivers correct data. The cache must never be slower than the wait used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Fetch request valid |
| req_ready | output | 1 | Controller can take a request |
| req_pc | input | AW | Byte address of the instruction to fetch |
| out_valid | output | 1 | Instruction valid |
| out_ready | input | 1 | Consumer takes the instruction |
| out_instr | output | DW | Fetched instruction word |
| flush | input | 1 | Redirect pulse (mispredict or exception entry) |
| cache_rd_en | output | 1 | One-cycle cache block read strobe |
| cache_rd_addr | output | AW | Block-aligned read address |
| cache_rd_data | input | WPB*DW | Whole block returned by the cache |
| cache_rd_ok | input | 1 | Cache data for the current read has settled |
| stall_cnt | output | CNT_W | Cycles spent issuing or waiting on cache reads |

## Verification
The hardest situation to reach is a redirect that lands while a read is still waiting. It must be followed by a hit on the old buffered block and then by a miss that must use the longest wait despite a stale hint. A directed sequence reaches it: a redirect while idle, a miss, a second redirect two cycles later, then fetches of the old and the new block. Random fetches over eight blocks with random output stalls then check the hint chain. Each miss's wait follows only from the last word of a block or a branch-flagged word actually handed over, and the cache model answers at a random true latency no larger than that wait.

// File: rtl/hintfetch_pkg.sv
package hintfetch_pkg;
  localparam int LAT_W = 3;
  typedef logic [LAT_W-1:0] lat_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_OUT   = 2'd3
  } fstate_e;

  function automatic lat_t worst_lat(input int num_lat);
    return (num_lat == 2) ? lat_t'(2) : lat_t'(5);
  endfunction
endpackage

// File: rtl/hintfetch_latmap.sv
module hintfetch_latmap
  import hintfetch_pkg::*;
#(
  parameter int NUM_LAT = 3,
  parameter int HINT_W  = 2
) (
  input  logic [HINT_W-1:0] code,
  output lat_t              lat
);
  generate
    if (NUM_LAT == 2) begin : g_two
      always_comb lat = code[0] ? lat_t'(2) : lat_t'(1);
    end else begin : g_three
      always_comb begin
        if (code >= HINT_W'(2)) lat = lat_t'(5);
        else                    lat = lat_t'(3) + lat_t'(code);
      end
    end
  endgenerate
endmodule

// File: rtl/hintfetch_timer.sv
module hintfetch_timer
  import hintfetch_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic abort,
  input  lat_t lat_in,
  output logic busy,
  output logic expire
);
  lat_t cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (abort) begin
      busy <= 1'b0;
    end else if (load) begin
      busy  <= 1'b1;
      cnt_q <= lat_in - lat_t'(1);
    end else if (busy) begin
      if (cnt_q == '0) busy <= 1'b0;
      else             cnt_q <= cnt_q - lat_t'(1);
    end
  end

  assign expire = busy && (cnt_q == '0);

  AST_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy); // R3
  AST_WAIT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !expire && !abort) |=> busy); // R3
endmodule

// File: rtl/hintfetch_linebuf.sv
module hintfetch_linebuf #(
  parameter int DW     = 32,
  parameter int WPB    = 4,
  parameter int TAG_W  = 28,
  parameter int WIDX_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fill,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic [WPB*DW-1:0] fill_data,
  input  logic [TAG_W-1:0]  look_tag,
  input  logic [WIDX_W-1:0] look_widx,
  output logic              hit,
  output logic [DW-1:0]     word
);
  logic             valid_q;
  logic [TAG_W-1:0] tag_q;
  logic [DW-1:0]    data_q [WPB];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      tag_q   <= '0;
    end else if (fill) begin
      valid_q <= 1'b1;
      tag_q   <= fill_tag;
    end
  end

  generate
    for (genvar g = 0; g < WPB; g++) begin : g_word
      always_ff @(posedge clk) begin
        if (fill) data_q[g] <= fill_data[g*DW +: DW];
      end
    end
  endgenerate

  assign hit  = valid_q && (tag_q == look_tag);
  assign word = data_q[look_widx];
endmodule

// File: rtl/hintfetch_ctrl.sv
module hintfetch_ctrl
  import hintfetch_pkg::*;
#(
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter int WPB      = 4,
  parameter int NUM_LAT  = 3,
  parameter int HINT_POS = 24,
  parameter int BR_POS   = 26,
  parameter int CNT_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [AW-1:0]     req_pc,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DW-1:0]     out_instr,
  input  logic              flush,
  output logic              cache_rd_en,
  output logic [AW-1:0]     cache_rd_addr,
  input  logic [WPB*DW-1:0] cache_rd_data,
  input  logic              cache_rd_ok,
  output logic [CNT_W-1:0]  stall_cnt
);
  localparam int   WIDX_W  = $clog2(WPB);
  localparam int   OFF     = WIDX_W + 2;
  localparam int   TAG_W   = AW - OFF;
  localparam int   HINT_W  = (NUM_LAT == 2) ? 1 : 2;
  localparam lat_t LAT_MAX = worst_lat(NUM_LAT);

  fstate_e            state_q;
  logic [TAG_W-1:0]   tag_q;
  logic [WIDX_W-1:0]  widx_q;
  logic [DW-1:0]      out_q;
  logic [HINT_W-1:0]  hint_q;
  logic               force_q;
  logic [CNT_W-1:0]   stall_q;

  logic [TAG_W-1:0]   req_tag;
  logic [WIDX_W-1:0]  req_widx;
  logic               accept, buf_hit, fill, delivered, tmr_load, tmr_busy, tmr_expire;
  logic [DW-1:0]      buf_word;
  lat_t               hint_lat, lat_used;

  assign req_tag   = req_pc[AW-1:OFF];
  assign req_widx  = req_pc[OFF-1:2];
  assign req_ready = !flush && ((state_q == ST_IDLE) || ((state_q == ST_OUT) && out_ready));
  assign accept    = req_valid && req_ready;
  assign out_valid = (state_q == ST_OUT);
  assign out_instr = out_q;
  assign delivered = out_valid && out_ready;
  assign tmr_load  = (state_q == ST_ISSUE) && !flush;
  assign fill      = (state_q == ST_WAIT) && tmr_expire && !flush;
  assign lat_used  = force_q ? LAT_MAX : hint_lat;

  assign cache_rd_en   = (state_q == ST_ISSUE);
  assign cache_rd_addr = {tag_q, {OFF{1'b0}}};
  assign stall_cnt     = stall_q;

  hintfetch_linebuf #(.DW(DW), .WPB(WPB), .TAG_W(TAG_W), .WIDX_W(WIDX_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .fill(fill), .fill_tag(tag_q), .fill_data(cache_rd_data),
    .look_tag(req_tag), .look_widx(req_widx), .hit(buf_hit), .word(buf_word)
  );

  hintfetch_latmap #(.NUM_LAT(NUM_LAT), .HINT_W(HINT_W)) u_map (
    .code(hint_q), .lat(hint_lat)
  );

  hintfetch_timer u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .abort(flush), .lat_in(lat_used),
    .busy(tmr_busy), .expire(tmr_expire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tag_q   <= '0;
      widx_q  <= '0;
      out_q   <= '0;
    end else if (flush) begin
      state_q <= ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE, ST_OUT: begin
          if (accept) begin
            tag_q  <= req_tag;
            widx_q <= req_widx;
            if (buf_hit) begin
              out_q   <= buf_word;
              state_q <= ST_OUT;
            end else begin
              state_q <= ST_ISSUE;
            end
          end else if (delivered) begin
            state_q <= ST_IDLE;
          end
        end
        ST_ISSUE: state_q <= ST_WAIT;
        ST_WAIT: begin
          if (tmr_expire) begin
            out_q   <= cache_rd_data[widx_q*DW +: DW];
            state_q <= ST_OUT;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // Longest wait after reset or redirect, cleared when a read is launched
  always_ff @(posedge clk) begin
    if (!rst_n)        force_q <= 1'b1;
    else if (flush)    force_q <= 1'b1;
    else if (tmr_load) force_q <= 1'b0;
  end

  // Hint pickup from a handed-over block-end or branch-flagged word
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hint_q <= '0;
    end else if (delivered && ((widx_q == WIDX_W'(WPB-1)) || out_q[BR_POS])) begin
      hint_q <= out_q[HINT_POS +: HINT_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) stall_q <= '0;
    else if ((state_q == ST_ISSUE) || (state_q == ST_WAIT)) stall_q <= stall_q + CNT_W'(1);
  end

  AST_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_pc[1:0] == 2'b00)); // R2
  AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cache_rd_en |=> !cache_rd_en); // R2
  AST_HIT_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && buf_hit) |=> (out_valid && !cache_rd_en)); // R1
  AST_WAIT_TIMED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT) |-> tmr_busy); // R3
  AST_HINT_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
    fill |-> cache_rd_ok); // R10
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !flush) |=> (out_valid && $stable(out_instr))); // R8
  AST_FLUSH_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !out_valid); // R6
endmodule

// File: tb/hintfetch_ctrl_tb_top.sv
`timescale 1ns/1ps
module hintfetch_ctrl_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [31:0]  req_pc = '0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [31:0]  out_instr;
  logic         flush = 1'b0;
  logic         cache_rd_en;
  logic [31:0]  cache_rd_addr;
  logic [127:0] cache_rd_data;
  logic         cache_rd_ok;
  logic [15:0]  stall_cnt;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  hintfetch_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready), .req_pc(req_pc),
    .out_valid(out_valid), .out_ready(out_ready), .out_instr(out_instr), .flush(flush),
    .cache_rd_en(cache_rd_en), .cache_rd_addr(cache_rd_addr), .cache_rd_data(cache_rd_data),
    .cache_rd_ok(cache_rd_ok), .stall_cnt(stall_cnt)
  );

  function automatic logic [31:0] wordf(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h00C3_5A17;
  endfunction

  function automatic int lmap(input logic [1:0] c);
    return (c >= 2'd2) ? 5 : 3 + int'(c);
  endfunction

  // Cache model: answers after true_lat cycles, junk before that
  int          true_lat = 1;
  int          rd_seen = 0;
  logic [31:0] rd_addr_q = '0;
  logic        pend = 1'b0;
  int          ccnt = 0;

  always @(posedge clk) begin
    if (cache_rd_en) begin
      pend      <= 1'b1;
      ccnt      <= true_lat - 1;
      rd_addr_q <= cache_rd_addr;
      rd_seen   <= rd_seen + 1;
    end else if (pend && ccnt != 0) begin
      ccnt <= ccnt - 1;
    end
  end

  assign cache_rd_ok = pend && (ccnt == 0);
  always_comb begin
    for (int w = 0; w < 4; w++)
      cache_rd_data[w*32 +: 32] = cache_rd_ok ? wordf(rd_addr_q + 32'(4*w)) : (32'hBAD0_0000 | 32'(w));
  end

  // Bench model
  bit          m_valid = 0;
  logic [27:0] m_tag = '0;
  bit          m_force = 1;
  logic [1:0]  m_hint = '0;
  int          m_stall = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_fetch(input logic [31:0] pc, input int hold);
    bit    hit = m_valid && (m_tag == pc[31:4]);
    bit    forced = m_force;
    int    L = hit ? 0 : (m_force ? 5 : lmap(m_hint));
    int    rd0 = rd_seen;
    int    cyc;
    string ttag;
    logic [31:0] w;
    if (!hit) true_lat = $urandom_range(1, L);
    @(negedge clk);
    check(req_ready == 1'b1, "R8 req_ready idle", req_ready, 1);
    req_valid = 1'b1;
    req_pc    = pc;
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 1;
    if (!hit) check(req_ready == 1'b0, "R3 req_ready low in miss", req_ready, 0);
    while (!out_valid && cyc < 60) begin
      @(negedge clk);
      cyc++;
    end
    ttag = hit ? "R1 hit timing" : (forced ? "R7 forced wait timing" : "R3/R4/R5 hinted wait timing");
    check(cyc == (hit ? 1 : 2 + L), ttag, cyc, hit ? 1 : 2 + L);
    w = wordf(pc);
    check(out_instr == w, (!hit && true_lat == L) ? "R2 R10 instr" : "R2 instr", out_instr, w);
    check(rd_seen - rd0 == (hit ? 0 : 1), hit ? "R1 no read" : "R2 one read", rd_seen - rd0, hit ? 0 : 1);
    if (!hit) begin
      check(rd_addr_q == {pc[31:4], 4'h0}, "R2 read address", rd_addr_q, {pc[31:4], 4'h0});
      m_force = 0;
      m_valid = 1;
      m_tag   = pc[31:4];
      m_stall += 1 + L;
    end
    check(int'(stall_cnt) == m_stall, "R9 stall count", stall_cnt, m_stall);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      check(out_valid && out_instr == w, "R8 hold under back-pressure", out_instr, w);
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    check(out_valid == 1'b0, "R8 handed over", out_valid, 0);
    if (pc[3:2] == 2'd3 || w[26]) m_hint = w[25:24];
  endtask

  task automatic pulse_flush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    m_force = 1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] pa;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R8 reset req_ready", req_ready, 1);
    check(out_valid == 1'b0, "R8 reset out_valid", out_valid, 0);
    check(rd_seen == 0, "R8 reset no read", rd_seen, 0);
    check(stall_cnt == 0, "R9 reset stall", stall_cnt, 0);

    // Directed: first miss forced, hits, walk to block end for hint pickup
    do_fetch(32'h0000_1004, 2);
    do_fetch(32'h0000_1000, 0);
    do_fetch(32'h0000_1008, 1);
    do_fetch(32'h0000_100C, 0);
    do_fetch(32'h0000_1020, 0);
    do_fetch(32'h0000_102C, 3);
    do_fetch(32'h0000_1040, 0);

    // Redirect in idle, then a miss abandoned mid-wait
    pulse_flush();
    pa = 32'h0000_1068;
    true_lat = 5;
    @(negedge clk);
    req_valid = 1'b1;
    req_pc    = pa;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    m_force = 1;
    m_stall += 2;
    for (int i = 0; i < 8; i++) begin
      check(out_valid == 1'b0, "R6 no delivery after redirect", out_valid, 0);
      @(negedge clk);
    end
    check(int'(stall_cnt) == m_stall, "R9 stall with redirect", stall_cnt, m_stall);
    do_fetch(32'h0000_1044, 0);   // R6: old block still buffered
    do_fetch(pa, 1);              // R7: forced longest wait

    // Random traffic
    for (int n = 0; n < 300; n++) begin
      logic [31:0] pc;
      if (($urandom_range(0, 1) == 0) && m_valid)
        pc = {m_tag, 2'($urandom_range(0, 3)), 2'b00};
      else
        pc = 32'h0000_1000 + 32'($urandom_range(0, 7) * 16 + $urandom_range(0, 3) * 4);
      if ($urandom_range(0, 19) == 0) pulse_flush();
      do_fetch(pc, $urandom_range(0, 3));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule